// File: doc/BRIEF.md
# Two-Wire Slave Write Buffer

This block is the receive side of a slave on a two-wire serial bus with a clock line and an open-drain data line. A fast system clock samples both lines through synchronisers. The block finds start and stop conditions on the sampled lines, shifts in bytes most significant bit first, and pulls the data line low to acknowledge each byte it accepts.

The first byte after a start holds a 7-bit device address and a direction bit. When the address matches the `DEV_ADDR` parameter and the direction bit asks for a write, the block accepts the data bytes that follow into a circular buffer of `DEPTH` entries. The master may send any number of bytes. Once more than `DEPTH` bytes have arrived, each new byte overwrites the oldest one. A stop condition ends the burst. The block then raises a one-cycle commit strobe, holds the stored byte count on `commit_cnt_o`, and lets the consumer read the kept bytes by index from oldest to newest. The count and the buffer contents stay readable until the next start condition.

`DEPTH` must be a power of two.

Top module: `twb_slave`

## Requirements
- R1: While reset is held, and afterwards until a transfer addresses the block, `sda_oe_o` is 0, `commit_o` is 0 and `commit_cnt_o` is 0.
- R2: An address byte of `{DEV_ADDR, 0}` (the address in bits 7..1, bit 0 = 0 for write) is acknowledged. `sda_oe_o` is 1 while the clock line is high during the ninth clock pulse, and it returns to 0 after the clock line falls at the end of that pulse. `sda_oe_o` rises only while the synchronised clock line is low.
- R3: An address byte with a different address, or with bit 0 = 1, is not acknowledged. No later byte is acknowledged or stored before the next start, and the stop that ends such a transfer raises no commit strobe.
- R4: After an accepted address, every complete data byte is acknowledged in its ninth clock pulse. Bits are taken most significant first, on the rising clock edge.
- R5: A stop condition that ends an accepted write raises `commit_o` for exactly one system clock cycle.
- R6: After the commit, `commit_cnt_o` equals the number of whole data bytes received, capped at `DEPTH`. For index k below that count, `rd_data_o` at `rd_idx_i = k` returns the k-th oldest of the most recent bytes kept.
- R7: A repeated start sets the count back to 0 and discards the bytes of the unfinished burst. Only the bytes of the transfer that then ends with a stop are committed.
- R8: A data byte cut short by a stop before its eighth bit is neither stored nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| commit_o | output | 1 | One-cycle strobe on a stop after an accepted write |
| commit_cnt_o | output | $clog2(DEPTH+1) | Number of bytes held, capped at DEPTH |
| rd_idx_i | input | $clog2(DEPTH) | Read index, 0 = oldest kept byte |
| rd_data_o | output | DW | Byte at the read index |

## Verification
A wrong state in the byte sequencer shows up within one byte time as a missing or misplaced acknowledge. The bench samples `sda_oe_o` in every ninth clock pulse, so a bit counter that is off by one, or a wrong address decision, is caught on the byte where it happens. A wrong write pointer or count does not appear on the bus. It appears only at the stop, in `commit_cnt_o` and in the order of the bytes read back, so every burst is read back in full over all kept indices. Bursts are run at lengths below, equal to and above the buffer depth.

// File: rtl/twb_pkg.sv
package twb_pkg;
    // Byte-level sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or after stop
        ST_ADDR,   // shifting the address byte
        ST_ACKW,   // byte complete, waiting for clock low
        ST_ACK,    // driving acknowledge during ninth pulse
        ST_DATA,   // shifting a data byte
        ST_SKIP    // not addressed: ignore until next start
    } seq_e;
endpackage

// File: rtl/twb_cond.sv
// Synchroniser and bus condition detector for clock and data lines.
module twb_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CW = 2 * STAGES;

    logic [CW-1:0] chain_q;
    logic [1:0]    prev_q;
    logic [1:0]    cur;

    assign cur = chain_q[CW-1 -: 2];

    // Reset to the idle bus level (both lines high)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 2'b11;
        end else begin
            chain_q <= {chain_q[CW-3:0], scl_i, sda_i};
            prev_q  <= cur;
        end
    end

    assign scl_lvl   = cur[1];
    assign sda_lvl   = cur[0];
    assign scl_rise  = cur[1] & ~prev_q[1];
    assign scl_fall  = ~cur[1] & prev_q[1];
    assign start_det = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
    assign stop_det  = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/twb_ring.sv
// Register-based circular store with one write and one read port.
module twb_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DEPTH*DW-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q <= '0;
            else if (wr_en && (wr_addr == AW'(g)))
                ent_q <= wr_data;
        end
        assign flat[g*DW +: DW] = ent_q;
    end

    assign rd_data = flat[rd_addr*DW +: DW];
endmodule

// File: rtl/twb_slave.sv
// Two-wire slave write receiver with a circular page buffer (DEPTH a power of two).
module twb_slave
    import twb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int SYNC  = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    output logic          commit_o,
    output logic [CW-1:0] commit_cnt_o,
    input  logic [AW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o
);
    typedef struct packed {
        seq_e          st;
        logic [BW-1:0] bitn;
        logic [DW-1:0] sh;
        logic          ackp;
        logic          own;
        logic          oe;
        logic [CW-1:0] cnt;
        logic [AW-1:0] wp;
        logic          commit;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [DW-1:0] next_byte;
    logic [AW-1:0] rd_addr;

    twb_cond #(.STAGES(SYNC)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign next_byte = {ctl_q.sh[DW-2:0], sda_lvl};

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.commit = 1'b0;
        wr_en        = 1'b0;
        if (start_det) begin
            // start or repeated start: drop any uncommitted burst
            ctl_d.st   = ST_ADDR;
            ctl_d.bitn = '0;
            ctl_d.cnt  = '0;
            ctl_d.wp   = '0;
            ctl_d.own  = 1'b0;
            ctl_d.oe   = 1'b0;
        end else if (stop_det) begin
            ctl_d.commit = ctl_q.own;
            ctl_d.st     = ST_IDLE;
            ctl_d.own    = 1'b0;
            ctl_d.oe     = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise) begin
                        ctl_d.sh   = next_byte;
                        ctl_d.bitn = ctl_q.bitn + 1'b1;
                        if (ctl_q.bitn == BW'(DW - 1)) begin
                            ctl_d.bitn = '0;
                            ctl_d.st   = ST_ACKW;
                            if (ctl_q.st == ST_ADDR) begin
                                ctl_d.ackp = (next_byte[DW-1:1] == DEV_ADDR) && !next_byte[0];
                            end else begin
                                ctl_d.ackp = 1'b1;
                                wr_en      = 1'b1;
                                ctl_d.wp   = ctl_q.wp + 1'b1;
                                if (ctl_q.cnt != CW'(DEPTH))
                                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_ACKW: begin
                    if (scl_fall) begin
                        if (ctl_q.ackp) begin
                            ctl_d.oe  = 1'b1;
                            ctl_d.own = 1'b1;
                            ctl_d.st  = ST_ACK;
                        end else begin
                            ctl_d.st  = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ctl_d.oe = 1'b0;
                        ctl_d.st = ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // oldest entry sits at the write pointer once the buffer has wrapped
    assign rd_addr = ((ctl_q.cnt == CW'(DEPTH)) ? ctl_q.wp : '0) + rd_idx_i;

    twb_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ctl_q.wp),
        .wr_data (next_byte),
        .rd_addr (rd_addr),
        .rd_data (rd_data_o)
    );

    assign sda_oe_o     = ctl_q.oe;
    assign commit_o     = ctl_q.commit;
    assign commit_cnt_o = ctl_q.cnt;

    p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);
    p_no_write_unowned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ctl_q.own);
    p_commit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    p_cnt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_cnt_o <= CW'(DEPTH));
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> (commit_cnt_o == '0));
endmodule

// File: tb/twb_slave_bench.sv
module twb_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] n;
        logic [7:0] seed;
        logic       ack;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'hA0, 8'd3,  8'h11, 1'b1},
        '{8'hA0, 8'd16, 8'h22, 1'b1},
        '{8'hA0, 8'd21, 8'h33, 1'b1},
        '{8'hA1, 8'd2,  8'h44, 1'b0},
        '{8'hA4, 8'd4,  8'h55, 1'b0},
        '{8'hA0, 8'd1,  8'h66, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] rd_idx = '0;
    wire  sda_oe, commit;
    wire  [4:0] ccnt;
    wire  [7:0] rdat;
    wire  sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    twb_slave u_twb_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .commit_o     (commit),
        .commit_cnt_o (ccnt),
        .rd_idx_i     (rd_idx),
        .rd_data_o    (rdat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int commits = 0;

    always @(posedge clk) if (commit === 1'b1) commits <= commits + 1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dat(input logic [7:0] seed, input int i);
        return (seed + 8'(i * 37)) ^ 8'(i);
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    w(Q);
        scl_m = 1'b1; w(2*Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        chk(req, int'(sda_oe), int'(exp_ack));
        w(Q);
        scl_m = 1'b0; w(Q);
        chk("R2 release after ninth pulse", int'(sda_oe), 0);
    endtask

    task automatic check_buffer(input int n, input logic [7:0] seed);
        int exp_cnt;
        exp_cnt = (n > 16) ? 16 : n;
        chk("R6 stored count", int'(ccnt), exp_cnt);
        for (int k = 0; k < exp_cnt; k++) begin
            rd_idx = 4'(k);
            w(1);
            chk("R6 oldest-to-newest data", int'(rdat), int'(dat(seed, n - exp_cnt + k)));
        end
    endtask

    task automatic run_vec(input vec_t v);
        int c0;
        c0 = commits;
        bus_start();
        send_byte(v.addr, v.ack, v.ack ? "R2 address ack" : "R3 address nack");
        for (int i = 0; i < int'(v.n); i++)
            send_byte(dat(v.seed, i), v.ack, v.ack ? "R4 data ack" : "R3 ignored data");
        bus_stop();
        chk("R5 commit pulse cycles", commits - c0, v.ack ? 1 : 0);
        if (v.ack) check_buffer(int'(v.n), v.seed);
    endtask

    initial begin
        int c0;
        // R1 reset state
        w(5);
        chk("R1 oe in reset", int'(sda_oe), 0);
        chk("R1 commit in reset", int'(commit), 0);
        rst_n = 1'b1;
        w(5);
        chk("R1 oe after reset", int'(sda_oe), 0);
        chk("R1 count after reset", int'(ccnt), 0);

        for (int v = 0; v < NVEC; v++) run_vec(VECS[v]);

        // R7 repeated start discards the unfinished burst
        c0 = commits;
        bus_start();
        send_byte(8'hA0, 1'b1, "R7 address ack");
        for (int i = 0; i < 5; i++) send_byte(dat(8'h77, i), 1'b1, "R7 data ack");
        bus_start();
        chk("R7 count cleared by repeated start", int'(ccnt), 0);
        chk("R7 no commit on repeated start", commits - c0, 0);
        send_byte(8'hA0, 1'b1, "R7 address ack again");
        for (int i = 0; i < 2; i++) send_byte(dat(8'h88, i), 1'b1, "R7 data ack again");
        bus_stop();
        chk("R7 single commit", commits - c0, 1);
        check_buffer(2, 8'h88);

        // R8 partial byte before stop is dropped
        c0 = commits;
        bus_start();
        send_byte(8'hA0, 1'b1, "R8 address ack");
        for (int i = 0; i < 3; i++) send_byte(dat(8'h99, i), 1'b1, "R8 data ack");
        for (int i = 0; i < 4; i++) send_bit(1'(i));
        bus_stop();
        chk("R8 commit", commits - c0, 1);
        check_buffer(3, 8'h99);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule